// File: doc/BRIEF.md
# USB Endpoint and Core Interrupt Aggregator

This block sits beside a USB on-the-go controller and gathers its single-cycle event pulses into two 32-bit pending registers. One register holds the endpoint events: transmit events for endpoints 0 to 15 and receive events for endpoints 1 to 15. The other holds nine core events, one of which is the VBUS-drive event. Software reaches both registers through a simple 32-bit register bus. Each register has a plain read view, a write-one-to-set alias, a write-one-to-clear alias, an enable mask with its own load, set and clear aliases, and a masked view.

The single level interrupt line to the CPU is gated by an end-of-interrupt handshake. Once the line has fired, it cannot fire again until software writes the end-of-interrupt register. A soft-reset bit clears all pending and mask state and re-arms the gate. A read-only status bit shows the live VBUS-drive request, and a revision register returns a fixed nonzero identifier.

Top module: `usb_irq_aggregator`

## Requirements
- R1: Offset 0x00 reads the constant REV_ID (default 0x0102_0035). Any offset outside the map reads zero.
- R2: Status offset 0x08 reads the live `vbus_drv_req` level in bit 0 and zero in every other bit. Writes to it change nothing.
- R3: Each event pulse sets its pending bit on the next clock edge. In the endpoint register (0x20), `ep_tx_evt[i]` lands on bit i (0..15) and `ep_rx_evt[i]` (endpoint i+1) lands on bit 17+i. Bit 16 always reads 0. In the core register (0x40), `core_evt[j]` lands on bit 16+j, so the VBUS-drive event `core_evt[8]` is bit 24. Core bits outside 16..24 always read 0.
- R4: Writing a set alias (endpoint 0x24, core 0x44) makes the written ones pending, the same as hardware events. Writes to the plain source views (0x20, 0x40) are ignored.
- R5: Writing a clear alias (endpoint 0x28, core 0x48) clears exactly the written ones. A hardware event on the same bit in the same cycle wins, so the bit stays pending.
- R6: Mask views are 0x2C and 0x4C. A write there loads the mask. Mask-set (0x30, 0x50) ORs ones in, and mask-clear (0x34, 0x54) removes them. Unused bit positions stay 0. The masked views (0x38, 0x58) read source AND mask.
- R7: `irq_out` rises on the edge after a masked pending bit becomes visible. After it has risen, it does not rise again until an end-of-interrupt write, even if new causes arrive. It falls once no masked bit is pending.
- R8: A write of any data to 0x60 (end of interrupt) drops `irq_out` on that edge and re-arms the gate. The line rises again on the following edge if a masked bit is still pending.
- R9: Writing 1 to bit 0 of control (0x04) clears both sources and both masks, drops `irq_out` and re-arms the gate. Events in that same cycle are discarded. Control reads 0.
- R10: A read strobe returns its data on `bus_rdata` with `bus_rvalid` high on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| ep_tx_evt | input | N_TX | Transmit endpoint event pulses |
| ep_rx_evt | input | N_RX | Receive endpoint event pulses (endpoints 1..N_RX) |
| core_evt | input | N_CORE | Core event pulses |
| vbus_drv_req | input | 1 | Live VBUS-drive request level |
| irq_out | output | 1 | Level interrupt to the CPU |

## Verification
The properties assume the bus issues at most one access per cycle: `bus_wr` and `bus_rd` are never high together, and addresses are word aligned. They also assume reset is held for at least one edge before any strobe or event. The bench drives each access in its own cycle, changing inputs only on the falling edge, and never overlaps a read with a write. Every event pulse lasts exactly one cycle. The one deliberate overlap, an event together with a clear write or a soft reset, is applied only where R5 and R9 define the outcome.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned DW = 32;

  localparam logic [7:0] OFS_REV       = 8'h00;
  localparam logic [7:0] OFS_CTRL      = 8'h04;
  localparam logic [7:0] OFS_STATUS    = 8'h08;
  localparam logic [7:0] OFS_EP_SRC    = 8'h20;
  localparam logic [7:0] OFS_EP_SET    = 8'h24;
  localparam logic [7:0] OFS_EP_CLR    = 8'h28;
  localparam logic [7:0] OFS_EP_MSK    = 8'h2C;
  localparam logic [7:0] OFS_EP_MSET   = 8'h30;
  localparam logic [7:0] OFS_EP_MCLR   = 8'h34;
  localparam logic [7:0] OFS_EP_MSTAT  = 8'h38;
  localparam logic [7:0] OFS_CO_SRC    = 8'h40;
  localparam logic [7:0] OFS_CO_SET    = 8'h44;
  localparam logic [7:0] OFS_CO_CLR    = 8'h48;
  localparam logic [7:0] OFS_CO_MSK    = 8'h4C;
  localparam logic [7:0] OFS_CO_MSET   = 8'h50;
  localparam logic [7:0] OFS_CO_MCLR   = 8'h54;
  localparam logic [7:0] OFS_CO_MSTAT  = 8'h58;
  localparam logic [7:0] OFS_EOI       = 8'h60;

  // Ones over [lsb, lsb+n) of a data word.
  function automatic logic [DW-1:0] span(input int lsb, input int n);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < DW; i++) begin
      if (i >= lsb && i < lsb + n) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         srst,
  input  logic [W-1:0] hw_evt,
  input  logic [W-1:0] wdata,
  input  logic         set_wr,
  input  logic         clr_wr,
  input  logic         mask_ld,
  input  logic         mask_set,
  input  logic         mask_clr,
  output logic [W-1:0] src,
  output logic [W-1:0] mask,
  output logic [W-1:0] masked,
  output logic         any
);
  logic [W-1:0] set_v, clr_v, mset_v, mclr_v;

  always_comb begin
    set_v  = set_wr   ? wdata : '0;
    clr_v  = clr_wr   ? wdata : '0;
    mset_v = mask_set ? wdata : '0;
    mclr_v = mask_clr ? wdata : '0;
  end

  // Hardware events are ORed after the clear, so they win over it.
  always_ff @(posedge clk) begin
    if (rst || srst) begin
      src  <= '0;
      mask <= '0;
    end else begin
      src <= ((src & ~clr_v) | set_v | hw_evt) & LIVE;
      if (mask_ld) mask <= wdata & LIVE;
      else         mask <= ((mask | mset_v) & ~mclr_v) & LIVE;
    end
  end

  assign masked = src & mask;
  assign any    = |masked;
endmodule

// File: rtl/irq_eoi_gate.sv
module irq_eoi_gate (
  input  logic clk,
  input  logic rst,
  input  logic srst,
  input  logic eoi_wr,
  input  logic pending,
  output logic irq_out
);
  logic fired;

  always_ff @(posedge clk) begin
    if (rst || srst || eoi_wr) begin
      irq_out <= 1'b0;
      fired   <= 1'b0;
    end else if (!fired && pending) begin
      irq_out <= 1'b1;
      fired   <= 1'b1;
    end else if (!pending) begin
      irq_out <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_irq_aggregator.sv
module usb_irq_aggregator #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned N_TX     = 16,
  parameter int unsigned N_RX     = 15,
  parameter int unsigned RX_LSB   = 17,
  parameter int unsigned N_CORE   = 9,
  parameter int unsigned CORE_LSB = 16,
  parameter logic [31:0] REV_ID   = 32'h0102_0035
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [N_TX-1:0]   ep_tx_evt,
  input  logic [N_RX-1:0]   ep_rx_evt,
  input  logic [N_CORE-1:0] core_evt,
  input  logic              vbus_drv_req,
  output logic              irq_out
);
  import irqagg_pkg::*;

  localparam logic [DW-1:0] EP_LIVE   = span(0, N_TX) | span(RX_LSB, N_RX);
  localparam logic [DW-1:0] CORE_LIVE = span(CORE_LSB, N_CORE);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic [DW-1:0] ep_hw, core_hw;
  logic [DW-1:0] ep_src, ep_mask, ep_masked;
  logic [DW-1:0] core_src, core_mask, core_masked;
  logic          ep_any, core_any, any_pending;
  logic          wr_srst, wr_eoi;
  logic [DW-1:0] rd_mux;

  always_comb begin
    ep_hw   = '0;
    core_hw = '0;
    for (int i = 0; i < int'(N_TX); i++)   ep_hw[i]            = ep_tx_evt[i];
    for (int i = 0; i < int'(N_RX); i++)   ep_hw[RX_LSB + i]   = ep_rx_evt[i];
    for (int i = 0; i < int'(N_CORE); i++) core_hw[CORE_LSB + i] = core_evt[i];
  end

  assign wr_srst = bus_wr && hit(bus_addr, OFS_CTRL) && bus_wdata[0];
  assign wr_eoi  = bus_wr && hit(bus_addr, OFS_EOI);

  irq_src_bank #(.W(DW), .LIVE(EP_LIVE)) u_ep_bank (
    .clk      (clk),
    .rst      (rst),
    .srst     (wr_srst),
    .hw_evt   (ep_hw),
    .wdata    (bus_wdata),
    .set_wr   (bus_wr && hit(bus_addr, OFS_EP_SET)),
    .clr_wr   (bus_wr && hit(bus_addr, OFS_EP_CLR)),
    .mask_ld  (bus_wr && hit(bus_addr, OFS_EP_MSK)),
    .mask_set (bus_wr && hit(bus_addr, OFS_EP_MSET)),
    .mask_clr (bus_wr && hit(bus_addr, OFS_EP_MCLR)),
    .src      (ep_src),
    .mask     (ep_mask),
    .masked   (ep_masked),
    .any      (ep_any)
  );

  irq_src_bank #(.W(DW), .LIVE(CORE_LIVE)) u_core_bank (
    .clk      (clk),
    .rst      (rst),
    .srst     (wr_srst),
    .hw_evt   (core_hw),
    .wdata    (bus_wdata),
    .set_wr   (bus_wr && hit(bus_addr, OFS_CO_SET)),
    .clr_wr   (bus_wr && hit(bus_addr, OFS_CO_CLR)),
    .mask_ld  (bus_wr && hit(bus_addr, OFS_CO_MSK)),
    .mask_set (bus_wr && hit(bus_addr, OFS_CO_MSET)),
    .mask_clr (bus_wr && hit(bus_addr, OFS_CO_MCLR)),
    .src      (core_src),
    .mask     (core_mask),
    .masked   (core_masked),
    .any      (core_any)
  );

  assign any_pending = ep_any || core_any;

  irq_eoi_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .srst    (wr_srst),
    .eoi_wr  (wr_eoi),
    .pending (any_pending),
    .irq_out (irq_out)
  );

  always_comb begin
    rd_mux = '0;
    if      (hit(bus_addr, OFS_REV))      rd_mux = REV_ID;
    else if (hit(bus_addr, OFS_STATUS))   rd_mux = {31'd0, vbus_drv_req};
    else if (hit(bus_addr, OFS_EP_SRC))   rd_mux = ep_src;
    else if (hit(bus_addr, OFS_EP_MSK))   rd_mux = ep_mask;
    else if (hit(bus_addr, OFS_EP_MSTAT)) rd_mux = ep_masked;
    else if (hit(bus_addr, OFS_CO_SRC))   rd_mux = core_src;
    else if (hit(bus_addr, OFS_CO_MSK))   rd_mux = core_mask;
    else if (hit(bus_addr, OFS_CO_MSTAT)) rd_mux = core_masked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              vbus_drv_req,
  input logic              irq_out,
  input logic              pending,
  input logic [31:0]       ep_src,
  input logic [31:0]       core_src
);
  logic eoi_w, srst_w, fired_c;

  assign eoi_w  = bus_wr && bus_addr == ADDR_W'(8'h60);
  assign srst_w = bus_wr && bus_addr == ADDR_W'(8'h04) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) fired_c <= 1'b0;
    else     fired_c <= (eoi_w || srst_w) ? 1'b0 : (fired_c || irq_out);
  end

  assert_status_live_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(8'h08)) |=> (bus_rdata == {31'd0, $past(vbus_drv_req)}));

  assert_rise_needs_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(pending));

  assert_no_rearm_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> !fired_c);

  assert_eoi_drops_R8: assert property (@(posedge clk) disable iff (rst)
    eoi_w |=> !irq_out);

  assert_srst_clears_R9: assert property (@(posedge clk) disable iff (rst)
    srst_w |=> (!irq_out && ep_src == 32'd0 && core_src == 32'd0));

  assert_read_latency_R10: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
endmodule

bind usb_irq_aggregator irqagg_checker #(.ADDR_W(ADDR_W)) u_irqagg_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .bus_rvalid   (bus_rvalid),
  .vbus_drv_req (vbus_drv_req),
  .irq_out      (irq_out),
  .pending      (any_pending),
  .ep_src       (ep_src),
  .core_src     (core_src)
);

// File: tb/tb_usb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_usb_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [15:0] ep_tx_evt = '0;
  logic [14:0] ep_rx_evt = '0;
  logic [8:0]  core_evt = '0;
  logic        vbus_drv_req = 1'b0;
  logic        irq_out;

  int n_run = 0, n_fail = 0;

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  usb_irq_aggregator dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ep_tx_evt(ep_tx_evt), .ep_rx_evt(ep_rx_evt), .core_evt(core_evt),
    .vbus_drv_req(vbus_drv_req), .irq_out(irq_out)
  );

  // Monitor: pops the scoreboard as read data arrives.
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      n_run++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R10 unexpected rvalid: actual %h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (bus_rdata !== e.v) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", e.tag, bus_rdata, e.v);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.v = e; it.tag = tag;
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; sb.push_back(it);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] tx, input logic [14:0] rx, input logic [8:0] co);
    @(negedge clk); ep_tx_evt = tx; ep_rx_evt = rx; core_evt = co;
    @(negedge clk); ep_tx_evt = '0; ep_rx_evt = '0; core_evt = '0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_run++;
    if (irq_out !== e) begin
      n_fail++;
      $display("FAIL %s: irq_out actual %b expected %b", tag, irq_out, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    n_run++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R10 missing read data: actual %0d left expected 0", sb.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // Reset state and fixed reads
    chk_irq(1'b0, "R7 reset");
    rd(8'h00, 32'h0102_0035, "R1 revision");
    rd(8'h10, 32'h0, "R1 unmapped 0x10");
    rd(8'h7C, 32'h0, "R1 unmapped 0x7C");
    rd(8'h20, 32'h0, "R3 ep src reset");
    rd(8'h08, 32'h0, "R2 status low");
    // Status follows the live level; writes do nothing
    vbus_drv_req = 1'b1;
    rd(8'h08, 32'h1, "R2 status high");
    wr(8'h08, 32'h0);
    rd(8'h08, 32'h1, "R2 status write ignored");
    vbus_drv_req = 1'b0;
    // Event placement, mask still zero
    pulse(16'h0008, 15'h0010, 9'h0);
    rd(8'h20, 32'h0020_0008, "R3 tx3 rx-ep5 bits");
    idle(2);
    chk_irq(1'b0, "R6 unmasked no irq");
    pulse(16'h0, 15'h0, 9'h100);
    rd(8'h40, 32'h0100_0000, "R3 vbus-drive event bit 24");
    // Enable one cause
    wr(8'h30, 32'h0020_0000);
    chk_irq(1'b0, "R7 one edge latency");
    idle(1);
    chk_irq(1'b1, "R7 line rises");
    rd(8'h38, 32'h0020_0000, "R6 masked view");
    rd(8'h2C, 32'h0020_0000, "R6 mask after set");
    // End of interrupt with cause still pending
    wr(8'h60, 32'hDEAD_BEEF);
    chk_irq(1'b0, "R8 eoi drops line");
    idle(1);
    chk_irq(1'b1, "R8 re-assert when pending");
    // Clear with the masked value
    wr(8'h28, 32'h0020_0000);
    idle(1);
    chk_irq(1'b0, "R7 line falls when cause gone");
    rd(8'h20, 32'h0000_0008, "R5 clear exact bits");
    // New cause without end of interrupt
    wr(8'h24, 32'h0020_0000);
    idle(3);
    chk_irq(1'b0, "R7 no re-assert before eoi");
    rd(8'h38, 32'h0020_0000, "R4 set alias pending");
    wr(8'h60, 32'h0);
    chk_irq(1'b0, "R8 eoi low");
    idle(1);
    chk_irq(1'b1, "R8 fires after eoi");
    // Set all bits, unused positions stay zero
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h20, 32'hFFFE_FFFF, "R3 ep bit16 stays zero");
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h40, 32'h01FF_0000, "R3 core field only");
    wr(8'h20, 32'h0);
    rd(8'h20, 32'hFFFE_FFFF, "R4 direct source write ignored");
    // Event and clear collide on bit 2
    @(negedge clk);
    ep_tx_evt = 16'h0004; bus_wr = 1'b1; bus_addr = 8'h28; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    ep_tx_evt = '0; bus_wr = 1'b0;
    rd(8'h20, 32'h0000_0004, "R5 event wins over clear");
    // Mask load, clear, set
    wr(8'h2C, 32'h0000_000C);
    rd(8'h2C, 32'h0000_000C, "R6 mask load");
    wr(8'h34, 32'h0000_0008);
    rd(8'h2C, 32'h0000_0004, "R6 mask clear");
    wr(8'h30, 32'h0001_0001);
    rd(8'h2C, 32'h0000_0005, "R6 mask set drops bit16");
    rd(8'h38, 32'h0000_0004, "R6 masked and");
    // Soft reset
    wr(8'h04, 32'h1);
    chk_irq(1'b0, "R9 line cleared");
    rd(8'h20, 32'h0, "R9 ep src cleared");
    rd(8'h2C, 32'h0, "R9 ep mask cleared");
    rd(8'h40, 32'h0, "R9 core src cleared");
    rd(8'h04, 32'h0, "R9 control reads zero");
    wr(8'h50, 32'h0100_0000);
    rd(8'h4C, 32'h0100_0000, "R6 core mask set");
    pulse(16'h0, 15'h0, 9'h100);
    chk_irq(1'b0, "R9 rearmed latency");
    idle(1);
    chk_irq(1'b1, "R9 fires without eoi after soft reset");
    rd(8'h58, 32'h0100_0000, "R6 core masked view");
    // Event in the soft-reset cycle is dropped
    @(negedge clk);
    ep_tx_evt = 16'h0001; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h1;
    @(negedge clk);
    ep_tx_evt = '0; bus_wr = 1'b0;
    rd(8'h20, 32'h0, "R9 event dropped during soft reset");
    idle(3);
    finish_run();
  end
endmodule